// File: doc/BRIEF.md
# Pairable Edge/Center PWM Generator

This block produces eight pulse-width-modulated outputs from a single bus clock. Each channel has an 8-bit period and an 8-bit duty value, an output polarity bit, and a choice of two counting styles. In edge mode the counter climbs and restarts. In centered mode it climbs and then descends, so the active pulse sits in the middle of a window twice as long. Two adjacent channels can be fused into one 16-bit channel for long periods or fine duty steps. That gives anywhere from eight narrow channels to four wide ones.

Channel timing comes from a shared clock generator. A free-running prescaler gives two base ticks, each a power-of-two fraction of the bus clock. Two scaled ticks then further divide a base tick by twice a programmable factor. Software writes configuration through a simple write-only port. Period and duty values are staged in holding registers and reach a running counter only when its current period ends, so waveforms never show a torn cycle.

Top module: `pwm_concat_top`

## Requirements
- R1: After reset every output is 0. A channel whose enable bit (address 0, bit n for channel n) is 0 drives 0 on its output within one cycle and keeps it there.
- R2: In edge mode (address 2, bit n = 0) a channel with period P > 0 and duty D < P repeats every P channel ticks, and is in its active state for D ticks per repetition.
- R3: In centered mode (address 2, bit n = 1) the counter climbs from 0 to P and falls back, so the output repeats every 2P ticks and is active for 2D contiguous ticks.
- R4: Polarity bit n at address 1 set to 1 makes the active state a high output. Set to 0, the output is inverted, so it is high for the inactive part of each repetition.
- R5: When D >= P, including P = 0, the output sits constantly at the active level. When D = 0 and P > 0, it sits constantly at the inactive level.
- R6: A channel tick lasts 2^E bus cycles when scaled-select bit n (address 4) is 0. It lasts 2^E * 2M bus cycles when that bit is 1. Channels 0, 1, 4 and 5 use bank A (E = address 5 bits 2:0, M = address 6). Channels 2, 3, 6 and 7 use bank B (E = address 5 bits 6:4, M = address 7). M = 0 means 256.
- R7: Setting bit k of address 3 fuses channels 2k and 2k+1. The period and duty are then 16 bits wide: the high byte comes from channel 2k's registers and the low byte from channel 2k+1's. The odd channel's enable, polarity, mode and clock bits govern the pair, the result appears on output 2k+1, and output 2k stays 0.
- R8: Period values (address 8+n) and duty values (address 16+n) written to a running channel take effect only when its current repetition ends. Values written to a disabled channel take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 8 | One PWM output per channel |

## Verification
The assertions assume that configuration changes arrive only through the write port, one register per cycle. They also assume reset is held long enough for the prescaler to start from zero. Under these assumptions, an output that moves without a preceding tick or write is a genuine fault.

The stimulus holds a channel disabled while it is being reprogrammed, except in the deliberate mid-period write of the buffering test. It keeps random periods, duties and dividers small enough that three full repetitions fit well inside the run.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_ENABLE    = 5'd0;
    localparam logic [ADDR_W-1:0] A_POLARITY  = 5'd1;
    localparam logic [ADDR_W-1:0] A_CENTER    = 5'd2;
    localparam logic [ADDR_W-1:0] A_FUSE      = 5'd3;
    localparam logic [ADDR_W-1:0] A_SCALED    = 5'd4;
    localparam logic [ADDR_W-1:0] A_PRESCALE  = 5'd5;
    localparam logic [ADDR_W-1:0] A_FACTOR_A  = 5'd6;
    localparam logic [ADDR_W-1:0] A_FACTOR_B  = 5'd7;
    localparam int                PERIOD_BASE = 8;
    localparam int                DUTY_BASE   = 16;
    localparam int                BANK_B_LSB  = 4;

    typedef struct packed {
        logic en;
        logic pol;
        logic center;
        logic scaled;
    } ch_cfg_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Bank used by a channel: pairs alternate between bank A and bank B.
    function automatic int bank_of(input int ch);
        return (ch >> 1) & 1;
    endfunction

endpackage

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
    import pwm_pkg::*;
#(
    parameter int EXP_W = 3,
    parameter int FAC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic [FAC_W-1:0] fac_a,
    input  logic [FAC_W-1:0] fac_b,
    output logic [1:0]       tick_base,
    output logic [1:0]       tick_scaled
);
    localparam int PRE_W = (1 << EXP_W) - 1;
    localparam int SC_W  = FAC_W + 2;

    logic [PRE_W-1:0] pre_cnt;

    always_ff @(posedge clk) begin
        if (rst) pre_cnt <= '0;
        else     pre_cnt <= pre_cnt + PRE_W'(1);
    end

    logic [EXP_W-1:0] exp_sel [2];
    logic [FAC_W-1:0] fac_sel [2];
    assign exp_sel[0] = exp_a;
    assign exp_sel[1] = exp_b;
    assign fac_sel[0] = fac_a;
    assign fac_sel[1] = fac_b;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [PRE_W-1:0] mask;
        logic [SC_W-1:0]  sc_cnt;
        logic [SC_W-1:0]  sc_lim;
        logic [SC_W-1:0]  fac_eff;

        always_comb begin
            for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(exp_sel[b]));
        end

        assign fac_eff = (fac_sel[b] == '0) ? SC_W'(1 << FAC_W) : SC_W'(fac_sel[b]);
        assign sc_lim  = (fac_eff << 1) - SC_W'(1);
        assign tick_base[b]   = ((pre_cnt & mask) == mask);
        assign tick_scaled[b] = tick_base[b] && (sc_cnt >= sc_lim);

        always_ff @(posedge clk) begin
            if (rst) begin
                sc_cnt <= '0;
            end else if (tick_base[b]) begin
                if (sc_cnt >= sc_lim) sc_cnt <= '0;
                else                  sc_cnt <= sc_cnt + SC_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic         center,
    input  logic         pol,
    input  logic [W-1:0] per_sh,
    input  logic [W-1:0] duty_sh,
    output logic         pwm
);
    logic [W-1:0] per_a;
    logic [W-1:0] duty_a;
    logic [W-1:0] cnt;
    dir_e         dir;

    logic [W-1:0] cnt_n;
    dir_e         dir_n;
    logic         wrap;

    always_comb begin
        cnt_n = cnt;
        dir_n = dir;
        wrap  = 1'b0;
        if (per_a == '0) begin
            cnt_n = '0;
            dir_n = DIR_UP;
            wrap  = 1'b1;
        end else if (!center) begin
            dir_n = DIR_UP;
            if (cnt >= per_a - W'(1)) begin
                cnt_n = '0;
                wrap  = 1'b1;
            end else begin
                cnt_n = cnt + W'(1);
            end
        end else if (dir == DIR_UP) begin
            if (cnt >= per_a - W'(1)) begin
                cnt_n = per_a;
                dir_n = DIR_DOWN;
            end else begin
                cnt_n = cnt + W'(1);
            end
        end else begin
            if (cnt <= W'(1)) begin
                cnt_n = '0;
                dir_n = DIR_UP;
                wrap  = 1'b1;
            end else begin
                cnt_n = cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_a  <= '0;
            duty_a <= '0;
            cnt    <= '0;
            dir    <= DIR_UP;
        end else if (!en) begin
            per_a  <= per_sh;
            duty_a <= duty_sh;
            cnt    <= '0;
            dir    <= DIR_UP;
        end else if (tick) begin
            cnt <= cnt_n;
            dir <= dir_n;
            if (wrap) begin
                per_a  <= per_sh;
                duty_a <= duty_sh;
            end
        end
    end

    logic active;
    always_comb begin
        if (duty_a >= per_a)      active = 1'b1;
        else if (dir == DIR_DOWN) active = (cnt <= duty_a);
        else                      active = (cnt < duty_a);
    end

    assign pwm = en && (pol ? active : !active);

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fuse,
    input  ch_cfg_t       cfg_even,
    input  ch_cfg_t       cfg_odd,
    input  logic          tick_base,
    input  logic          tick_scaled,
    input  logic [DW-1:0] per_even,
    input  logic [DW-1:0] per_odd,
    input  logic [DW-1:0] duty_even,
    input  logic [DW-1:0] duty_odd,
    output logic          out_even,
    output logic          out_odd
);
    localparam int WIDE_W = 2 * DW;

    logic [WIDE_W-1:0] wide_per;
    logic [WIDE_W-1:0] wide_duty;
    logic              tick_odd;
    logic              tick_even;
    logic              en_even;
    logic              pwm_even;

    assign wide_per  = fuse ? {per_even, per_odd}   : {{DW{1'b0}}, per_odd};
    assign wide_duty = fuse ? {duty_even, duty_odd} : {{DW{1'b0}}, duty_odd};
    assign tick_odd  = cfg_odd.scaled  ? tick_scaled : tick_base;
    assign tick_even = cfg_even.scaled ? tick_scaled : tick_base;
    assign en_even   = cfg_even.en && !fuse;

    pwm_engine #(.W(WIDE_W)) u_odd (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_odd.en),
        .tick    (tick_odd),
        .center  (cfg_odd.center),
        .pol     (cfg_odd.pol),
        .per_sh  (wide_per),
        .duty_sh (wide_duty),
        .pwm     (out_odd)
    );

    pwm_engine #(.W(DW)) u_even (
        .clk     (clk),
        .rst     (rst),
        .en      (en_even),
        .tick    (tick_even),
        .center  (cfg_even.center),
        .pol     (cfg_even.pol),
        .per_sh  (per_even),
        .duty_sh (duty_even),
        .pwm     (pwm_even)
    );

    assign out_even = pwm_even && !fuse;

endmodule

// File: rtl/pwm_concat_top.sv
module pwm_concat_top
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int EXP_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int NUM_PAIR = NUM_CH / 2;

    logic [NUM_CH-1:0]   en_r;
    logic [NUM_CH-1:0]   pol_r;
    logic [NUM_CH-1:0]   cen_r;
    logic [NUM_CH-1:0]   scl_r;
    logic [NUM_PAIR-1:0] fuse_r;
    logic [EXP_W-1:0]    exp_a_r;
    logic [EXP_W-1:0]    exp_b_r;
    logic [DATA_W-1:0]   fac_a_r;
    logic [DATA_W-1:0]   fac_b_r;
    logic [DATA_W-1:0]   per_sh  [NUM_CH];
    logic [DATA_W-1:0]   duty_sh [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r    <= '0;
            pol_r   <= '0;
            cen_r   <= '0;
            scl_r   <= '0;
            fuse_r  <= '0;
            exp_a_r <= '0;
            exp_b_r <= '0;
            fac_a_r <= '0;
            fac_b_r <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_ENABLE:   en_r    <= wr_data[NUM_CH-1:0];
                A_POLARITY: pol_r   <= wr_data[NUM_CH-1:0];
                A_CENTER:   cen_r   <= wr_data[NUM_CH-1:0];
                A_SCALED:   scl_r   <= wr_data[NUM_CH-1:0];
                A_FUSE:     fuse_r  <= wr_data[NUM_PAIR-1:0];
                A_PRESCALE: begin
                    exp_a_r <= wr_data[EXP_W-1:0];
                    exp_b_r <= wr_data[BANK_B_LSB +: EXP_W];
                end
                A_FACTOR_A: fac_a_r <= wr_data;
                A_FACTOR_B: fac_b_r <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                per_sh[ch]  <= '0;
                duty_sh[ch] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(PERIOD_BASE + ch)) per_sh[ch]  <= wr_data;
                if (wr_addr == ADDR_W'(DUTY_BASE + ch))   duty_sh[ch] <= wr_data;
            end
        end
    end

    logic [1:0] tick_base;
    logic [1:0] tick_scaled;

    pwm_clkgen #(.EXP_W(EXP_W), .FAC_W(DATA_W)) u_clkgen (
        .clk         (clk),
        .rst         (rst),
        .exp_a       (exp_a_r),
        .exp_b       (exp_b_r),
        .fac_a       (fac_a_r),
        .fac_b       (fac_b_r),
        .tick_base   (tick_base),
        .tick_scaled (tick_scaled)
    );

    ch_cfg_t cfg [NUM_CH];
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
        assign cfg[ch] = '{en: en_r[ch], pol: pol_r[ch], center: cen_r[ch], scaled: scl_r[ch]};
    end

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        localparam int BANK = bank_of(2 * k);

        pwm_pair #(.DW(DATA_W)) u_pair (
            .clk         (clk),
            .rst         (rst),
            .fuse        (fuse_r[k]),
            .cfg_even    (cfg[2*k]),
            .cfg_odd     (cfg[2*k+1]),
            .tick_base   (tick_base[BANK]),
            .tick_scaled (tick_scaled[BANK]),
            .per_even    (per_sh[2*k]),
            .per_odd     (per_sh[2*k+1]),
            .duty_even   (duty_sh[2*k]),
            .duty_odd    (duty_sh[2*k+1]),
            .out_even    (pwm_out[2*k]),
            .out_odd     (pwm_out[2*k+1])
        );
    end

endmodule

// File: rtl/pwm_concat_sva.sv
module pwm_concat_sva #(
    parameter int NUM_CH = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [NUM_CH-1:0]   en_r,
    input logic [NUM_CH/2-1:0] fuse_r,
    input logic [1:0]          tick_base,
    input logic [1:0]          tick_scaled,
    input logic [NUM_CH-1:0]   pwm_out
);
    for (genvar b = 0; b < 2; b++) begin : g_bank
        // R6: a scaled tick is always a subset of its bank's base ticks
        p_scaled_subset_r6: assert property (@(posedge clk) disable iff (rst)
            tick_scaled[b] |-> tick_base[b]);
    end

    for (genvar k = 0; k < NUM_CH / 2; k++) begin : g_pair
        p_even_silent_r7: assert property (@(posedge clk) disable iff (rst)
            fuse_r[k] |-> !pwm_out[2*k]);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        p_disabled_low_r1: assert property (@(posedge clk) disable iff (rst)
            ($past(!en_r[ch]) && !en_r[ch]) |-> !pwm_out[ch]);
    end

    p_quiet_no_event_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && $past(tick_base == 2'b00)) |-> $stable(pwm_out));

endmodule

module pwm_engine_sva #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per_a
);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= per_a);

    p_reload_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$stable(per_a)) |-> (cnt == '0));

endmodule

bind pwm_concat_top pwm_concat_sva #(.NUM_CH(NUM_CH)) u_top_sva (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .en_r        (en_r),
    .fuse_r      (fuse_r),
    .tick_base   (tick_base),
    .tick_scaled (tick_scaled),
    .pwm_out     (pwm_out)
);

bind pwm_engine pwm_engine_sva #(.W(W)) u_eng_sva (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .cnt   (cnt),
    .per_a (per_a)
);

// File: tb/pwm_concat_top_tb_top.sv
module pwm_concat_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_concat_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 5'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Ticks per repetition and active ticks, from the requirements
    function automatic int tick_len(input int e, input bit scl, input int m);
        int mm = (m == 0) ? 256 : m;
        return (1 << e) * (scl ? 2 * mm : 1);
    endfunction

    task automatic setup(input int ch, input int per, input int duty, input bit cen,
                         input bit pol, input bit scl, input int ea, input int eb,
                         input int ma, input int mb);
        wr(0, 0);
        wr(3, 0);
        wr(8 + ch, per);
        wr(16 + ch, duty);
        wr(1, pol << ch);
        wr(2, cen << ch);
        wr(4, scl << ch);
        wr(5, (eb << 4) | ea);
        wr(6, ma);
        wr(7, mb);
        wr(0, 1 << ch);
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        int prev  = int'(pwm_out[ch]);
        int edges = 0;
        int cnt   = 0;
        int h     = 0;
        per = -1;
        hi  = -1;
        for (int i = 0; i < 20000; i++) begin
            int cur;
            @(negedge clk);
            cur = int'(pwm_out[ch]);
            if (cur == 1 && prev == 0) begin
                edges++;
                if (edges >= 3) begin
                    per = cnt;
                    hi  = h;
                    break;
                end
                cnt = 0;
                h   = 0;
            end
            cnt++;
            h += cur;
            prev = cur;
        end
    endtask

    task automatic count_high(input int ch, input int len, output int highs);
        highs = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            highs += int'(pwm_out[ch]);
        end
    endtask

    task automatic run_case(input string req, input int ch, input int per, input int duty,
                            input bit cen, input bit pol, input bit scl,
                            input int ea, input int eb, input int ma, input int mb);
        int t, ep, eh, mp, mh;
        int bank = (ch >> 1) & 1;
        t  = bank ? tick_len(eb, scl, mb) : tick_len(ea, scl, ma);
        ep = (cen ? 2 * per : per) * t;
        eh = (cen ? 2 * duty : duty) * t;
        if (!pol) eh = ep - eh;
        setup(ch, per, duty, cen, pol, scl, ea, eb, ma, mb);
        measure(ch, mp, mh);
        check(mp == ep, {req, " period"}, mp, ep);
        check(mh == eh, {req, " high time"}, mh, eh);
    endtask

    initial begin
        int mp, mh, hs;
        void'($urandom(32'h5EED_0123));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(pwm_out == 8'h00, "R1 reset outputs", int'(pwm_out), 0);

        // R2: edge mode
        run_case("R2 edge ch0", 0, 10, 3, 1'b0, 1'b1, 1'b0, 0, 0, 1, 1);
        // R3: centered mode
        run_case("R3 center ch3", 3, 6, 2, 1'b1, 1'b1, 1'b0, 0, 0, 1, 1);
        // R4: inverted polarity
        run_case("R4 inverted ch5", 5, 8, 2, 1'b0, 1'b0, 1'b0, 0, 0, 1, 1);
        run_case("R4 inverted center ch4", 4, 5, 2, 1'b1, 1'b0, 1'b0, 0, 0, 1, 1);
        // R6: scaled clock on bank B, bank A set differently
        run_case("R6 scaled bank B ch2", 2, 4, 1, 1'b0, 1'b1, 1'b1, 0, 1, 1, 3);
        // R6: power-of-two base on bank B
        run_case("R6 base bank B ch6", 6, 5, 2, 1'b0, 1'b1, 1'b0, 0, 2, 1, 1);
        // R6: scaled bank A
        run_case("R6 scaled bank A ch1", 1, 3, 1, 1'b1, 1'b1, 1'b1, 1, 0, 2, 5);

        // R5: constant levels
        setup(1, 5, 7, 1'b0, 1'b1, 1'b0, 0, 0, 1, 1);
        count_high(1, 40, hs);
        check(hs == 40, "R5 duty above period", hs, 40);
        setup(1, 0, 0, 1'b0, 1'b1, 1'b0, 0, 0, 1, 1);
        count_high(1, 40, hs);
        check(hs == 40, "R5 zero period", hs, 40);
        setup(1, 5, 0, 1'b1, 1'b1, 1'b0, 0, 0, 1, 1);
        count_high(1, 40, hs);
        check(hs == 0, "R5 zero duty", hs, 0);

        // R7: fused pair 1 (channels 2 and 3), period 0x0104, duty 0x0082
        wr(0, 0);
        wr(8 + 2, 8'h01);
        wr(8 + 3, 8'h04);
        wr(16 + 2, 8'h00);
        wr(16 + 3, 8'h82);
        wr(1, 8'h0C);
        wr(2, 8'h00);
        wr(4, 8'h00);
        wr(5, 8'h00);
        wr(3, 8'h02);
        wr(0, 8'h0C);
        measure(3, mp, mh);
        check(mp == 260, "R7 fused period", mp, 260);
        check(mh == 130, "R7 fused high time", mh, 130);
        count_high(2, 300, hs);
        check(hs == 0, "R7 even output silent", hs, 0);
        wr(3, 8'h00);

        // R8: mid-period duty write waits for the period end
        setup(0, 20, 3, 1'b0, 1'b1, 1'b0, 0, 0, 1, 1);
        measure(0, mp, mh);
        for (int i = 0; i < 40 && pwm_out[0]; i++) @(negedge clk);
        @(negedge clk);
        wr(16, 15);
        count_high(0, 10, hs);
        check(hs == 0, "R8 duty held until period end", hs, 0);
        measure(0, mp, mh);
        check(mh == 15, "R8 new duty after period end", mh, 15);
        // R8: disabled channel takes new values at once
        wr(0, 0);
        wr(8, 7);
        wr(16, 2);
        wr(0, 1);
        measure(0, mp, mh);
        check(mp == 7 && mh == 2, "R8 load while disabled", mp * 100 + mh, 702);

        // R1: disabling a running channel
        wr(0, 0);
        @(negedge clk);
        count_high(0, 30, hs);
        check(hs == 0, "R1 disabled output low", hs, 0);

        // R2 R3 R4 R6: random configurations
        for (int it = 0; it < 10; it++) begin
            int ch   = $urandom_range(7, 0);
            int per  = $urandom_range(16, 2);
            int duty = $urandom_range(per - 1, 1);
            bit cen  = 1'($urandom_range(1, 0));
            bit pol  = 1'($urandom_range(1, 0));
            bit scl  = 1'($urandom_range(1, 0));
            int ea   = $urandom_range(2, 0);
            int eb   = $urandom_range(2, 0);
            int ma   = $urandom_range(3, 1);
            int mb   = $urandom_range(3, 1);
            run_case("R2 R3 R4 R6 random", ch, per, duty, cen, pol, scl, ea, eb, ma, mb);
        end

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule